// File: doc/BRIEF.md
# Two-Wire Slave Port for a 16-bit Register Bank

This block is a target on a two-wire serial bus, answering to the fixed 7-bit device address 0011000. The bus master selects a register with an 8-bit register pointer. Every register holds 16 bits, and each register crosses the bus as a pair of bytes, high byte first. The block never drives the clock line. On the data line it can only pull low, so the surrounding pad logic turns `sda_oe` into an open-drain driver and returns the wired level on `sda_i`.

A write sends the device address with the direction bit clear, then the pointer, then one or more byte pairs. Each completed pair is handed to the register bank as a single-cycle strobe, and the pointer then steps by one. A read first sets the pointer with a short write. The master then issues a repeated START and the device address with the direction bit set, and the block returns byte pairs from `rd_data` at the current pointer. The master acknowledges each byte it receives. A not-acknowledge ends the read, and the block then stays off the bus until it sees a new START.

Both bus lines pass through a synchronizer and a glitch filter before START, STOP and clock edges are decoded. The register contents themselves live outside this block.

Top module: `i2cs_reg16`

## Requirements
- R1: The block acknowledges an address byte (SDA low through the ninth clock) only when its upper seven bits equal 0011000. For any other address it leaves SDA released for the rest of that transfer, until the next START, and performs no register write.
- R2: In a write (address bit 0 = 0), the block acknowledges the pointer byte and every data byte that follows.
- R3: A register write is issued only after the low byte of a pair has been acknowledged. It is a one-cycle `wr_en` pulse with `wr_addr` equal to the pointer and `wr_data` equal to {high byte, low byte}. A high byte followed by STOP writes nothing.
- R4: After each committed pair the pointer steps by one, wrapping from 0xFF to 0x00, so successive pairs in one write land in consecutive registers.
- R5: In a read (address bit 0 = 1), the block sends bits [15:8] and then bits [7:0] of `rd_data` for the register at `rd_addr`, most significant bit first.
- R6: During a read the pointer steps by one after each complete pair. A read that stops after the high byte leaves the pointer unchanged.
- R7: After a master not-acknowledge, the block keeps SDA released for any further clocks until the next START.
- R8: A STOP releases SDA and returns the block to idle. The pointer keeps its value across transfers.
- R9: `sda_oe` changes only while the filtered SCL is low.
- R10: A pulse on SCL shorter than FILT_LEN (default 4) clock cycles after synchronization is ignored and does not disturb a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| rd_addr | output | 8 | Register pointer, used as the read address |
| rd_data | input | 16 | Content of the register at `rd_addr` |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register written on `wr_en` |
| wr_data | output | 16 | Value written on `wr_en` |

## Verification
Writes are tried with a single pair, with three pairs that cross the top of the pointer range, and with a lone high byte. Together these separate commit timing, pointer stepping and wrap-around from simple byte capture. Reads use a pointer-setting write followed by a repeated START and acknowledged pairs. Further reads continue from the retained pointer, stop after one byte with a not-acknowledge, or clock on after a not-acknowledge; these tell the increment point and the bus-release rules apart. A foreign device address checks that the block stays silent. A write carrying short SCL spikes inside every bit shows whether the filter rejects them.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef struct packed {
        st_e         st;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  hi;
        logic [7:0]  ptr;
        logic        rw;
        logic        need_reg;
        logic        half;
        logic        commit;
        logic        oe;
        logic        wen;
        logic [7:0]  waddr;
        logic [15:0] wdata;
    } ctl_s;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   filt_d, filt_q;
    logic                   s_out;

    assign s_out = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], raw};
        filt_d = filt_q;
        cnt_d  = '0;
        if (s_out != filt_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                filt_d = s_out;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign filt = filt_q;
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
        start    = scl & scl_q & sda_q & ~sda;
        stop     = scl & scl_q & ~sda_q & sda;
    end
endmodule

// File: rtl/i2cs_reg16.sv
module i2cs_reg16 #(
    parameter logic [6:0] DEV_ADDR    = 7'b0011000,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [7:0]  rd_addr,
    input  logic [15:0] rd_data,
    output logic        wr_en,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data
);
    import i2cs_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f;
    logic ev_rise, ev_fall, ev_start, ev_stop;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cs_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2cs_bus_events u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .scl_rise(ev_rise),
        .scl_fall(ev_fall),
        .start   (ev_start),
        .stop    (ev_stop)
    );

    ctl_s c_q, c_d;

    always_comb begin
        logic [7:0] tx;
        tx       = '0;
        c_d      = c_q;
        c_d.wen  = 1'b0;
        if (ev_start) begin
            c_d.st     = ST_ADDR;
            c_d.cnt    = '0;
            c_d.oe     = 1'b0;
            c_d.commit = 1'b0;
        end else if (ev_stop) begin
            c_d.st     = ST_IDLE;
            c_d.cnt    = '0;
            c_d.oe     = 1'b0;
            c_d.commit = 1'b0;
        end else begin
            case (c_q.st)
                ST_ADDR, ST_RX: begin
                    if (ev_rise && c_q.cnt < 4'd8) begin
                        c_d.sh  = {c_q.sh[6:0], sda_f};
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (ev_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt = '0;
                        c_d.st  = ST_ACK;
                        c_d.oe  = 1'b1;
                        if (c_q.st == ST_ADDR) begin
                            if (c_q.sh[7:1] == DEV_ADDR) begin
                                c_d.rw       = c_q.sh[0];
                                c_d.need_reg = ~c_q.sh[0];
                                c_d.half     = 1'b0;
                            end else begin
                                c_d.st = ST_IDLE;
                                c_d.oe = 1'b0;
                            end
                        end else if (c_q.need_reg) begin
                            c_d.ptr      = c_q.sh;
                            c_d.need_reg = 1'b0;
                            c_d.half     = 1'b0;
                        end else if (!c_q.half) begin
                            c_d.hi   = c_q.sh;
                            c_d.half = 1'b1;
                        end else begin
                            c_d.wdata  = {c_q.hi, c_q.sh};
                            c_d.half   = 1'b0;
                            c_d.commit = 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        if (c_q.rw) begin
                            c_d.sh   = rd_data[15:8];
                            c_d.oe   = ~rd_data[15];
                            c_d.half = 1'b0;
                            c_d.st   = ST_TX;
                        end else begin
                            c_d.st = ST_RX;
                            if (c_q.commit) begin
                                c_d.wen    = 1'b1;
                                c_d.waddr  = c_q.ptr;
                                c_d.ptr    = c_q.ptr + 8'd1;
                                c_d.commit = 1'b0;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (ev_fall) begin
                        if (c_q.cnt == 4'd7) begin
                            c_d.oe  = 1'b0;
                            c_d.cnt = '0;
                            c_d.st  = ST_MACK;
                        end else begin
                            c_d.sh  = {c_q.sh[6:0], 1'b0};
                            c_d.oe  = ~c_q.sh[6];
                            c_d.cnt = c_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev_rise) begin
                        if (c_q.half) begin
                            c_d.ptr = c_q.ptr + 8'd1;
                        end
                        if (sda_f) begin
                            c_d.st = ST_IDLE;
                        end
                    end else if (ev_fall) begin
                        tx       = c_q.half ? rd_data[15:8] : rd_data[7:0];
                        c_d.sh   = tx;
                        c_d.oe   = ~tx[7];
                        c_d.half = ~c_q.half;
                        c_d.cnt  = '0;
                        c_d.st   = ST_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe  = c_q.oe;
    assign rd_addr = c_q.ptr;
    assign wr_en   = c_q.wen;
    assign wr_addr = c_q.waddr;
    assign wr_data = c_q.wdata;
endmodule

// File: rtl/i2cs_reg16_chk.sv
module i2cs_reg16_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       ev_start,
    input logic       ev_stop,
    input logic       sda_oe,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] rd_addr
);
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> rd_addr == wr_addr + 8'd1);

    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    assert_start_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe);

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !sda_oe);
endmodule

bind i2cs_reg16 i2cs_reg16_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .ev_start(ev_start),
    .ev_stop (ev_stop),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr)
);

// File: tb/tb_i2cs_reg16.sv
module tb_i2cs_reg16;
    localparam int Q = 25;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        glitch_en = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  rd_addr;
    logic [15:0] rd_data;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [15:0] wr_data;

    logic [15:0] regs [256];
    logic [15:0] exp_regs [256];
    int n_chk = 0, n_fail = 0, wr_count = 0, oe_viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign rd_data  = regs[rd_addr];

    i2cs_reg16 dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    function automatic logic [15:0] init_val(int a);
        return 16'(a * 257) ^ 16'h5A3C;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) regs[i] <= init_val(i);
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
            wr_count <= wr_count + 1;
        end
    end

    // R9 monitor: SDA drive may only change while the bus clock is low
    always @(negedge clk) begin
        if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;
        if (glitch_en) begin
            repeat (Q / 2) @(negedge clk);
            m_scl = 1'b1;
            repeat (2) @(negedge clk);
            m_scl = 1'b0;
            repeat (Q - Q / 2 - 2) @(negedge clk);
        end else begin
            qw(1);
        end
        m_scl = 1'b1;
        qw(2);
        m_scl = 1'b0;
        qw(1);
    endtask

    task automatic read_bit(output logic b);
        m_sda = 1'b1;
        qw(1);
        m_scl = 1'b1;
        qw(1);
        b = sda_line;
        qw(1);
        m_scl = 1'b0;
        qw(1);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(1);
        m_scl = 1'b1; qw(1);
        m_sda = 1'b0; qw(1);
        m_scl = 1'b0; qw(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(1);
        m_scl = 1'b1; qw(1);
        m_sda = 1'b1; qw(1);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        read_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic t_reset();
        chk("R8 reset sda_oe", 32'(sda_oe), 0);
        chk("R3 reset wr_en", 32'(wr_en), 0);
        chk("R4 reset pointer", 32'(rd_addr), 0);
    endtask

    task automatic t_single_write();
        logic a0, a1, a2, a3;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'h30, a0);
        send_byte(8'h10, a1);
        send_byte(8'hBE, a2);
        send_byte(8'hEF, a3);
        bus_stop();
        exp_regs[8'h10] = 16'hBEEF;
        chk("R1 address ack", 32'(a0), 1);
        chk("R2 pointer byte ack", 32'(a1), 1);
        chk("R2 data byte acks", 32'(a2 & a3), 1);
        chk("R3 written value", 32'(regs[8'h10]), 32'(exp_regs[8'h10]));
        chk("R3 one write", 32'(wr_count - w0), 1);
        chk("R4 pointer after pair", 32'(rd_addr), 32'h11);
        chk("R8 released after stop", 32'(sda_oe), 0);
    endtask

    task automatic t_wrap_write();
        logic a;
        logic all_ack;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'h30, a); all_ack &= a;
        send_byte(8'hFE, a); all_ack &= a;
        for (int g = 0; g < 3; g++) begin
            send_byte(8'(8'h11 * (g + 1)), a); all_ack &= a;
            send_byte(8'(8'h11 * (g + 1)), a); all_ack &= a;
        end
        bus_stop();
        exp_regs[8'hFE] = 16'h1111;
        exp_regs[8'hFF] = 16'h2222;
        exp_regs[8'h00] = 16'h3333;
        chk("R2 all bytes acked", 32'(all_ack), 1);
        chk("R4 reg FE", 32'(regs[8'hFE]), 32'(exp_regs[8'hFE]));
        chk("R4 reg FF", 32'(regs[8'hFF]), 32'(exp_regs[8'hFF]));
        chk("R4 wrap reg 00", 32'(regs[8'h00]), 32'(exp_regs[8'h00]));
        chk("R4 pointer after wrap", 32'(rd_addr), 32'h01);
    endtask

    task automatic t_partial_write();
        logic a;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'h30, a);
        send_byte(8'h20, a);
        send_byte(8'h77, a);
        bus_stop();
        chk("R3 lone high byte no write", 32'(wr_count - w0), 0);
        chk("R3 reg 20 unchanged", 32'(regs[8'h20]), 32'(exp_regs[8'h20]));
    endtask

    task automatic t_wrong_addr();
        logic a0, a1, a2;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'h32, a0);
        send_byte(8'h05, a1);
        send_byte(8'h00, a2);
        send_byte(8'h00, a2);
        bus_stop();
        chk("R1 foreign address no ack", 32'(a0), 0);
        chk("R1 silent afterwards", 32'(a1 | a2), 0);
        chk("R1 no write", 32'(wr_count - w0), 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b0, b1, b2, b3, bx;
        bus_start();
        send_byte(8'h30, a);
        send_byte(8'h10, a);
        bus_start();
        send_byte(8'h31, a);
        chk("R5 read address ack", 32'(a), 1);
        recv_byte(1'b0, b0);
        recv_byte(1'b0, b1);
        recv_byte(1'b0, b2);
        recv_byte(1'b1, b3);
        chk("R5 high byte reg 10", 32'(b0), 32'(exp_regs[8'h10][15:8]));
        chk("R5 low byte reg 10", 32'(b1), 32'(exp_regs[8'h10][7:0]));
        chk("R6 reg 11 pair", 32'({b2, b3}), 32'(exp_regs[8'h11]));
        recv_byte(1'b1, bx);
        chk("R7 released after nack", 32'(bx), 32'hFF);
        bus_stop();
        chk("R6 pointer after two pairs", 32'(rd_addr), 32'h12);
    endtask

    task automatic t_read_retained();
        logic a;
        logic [7:0] b0, b1;
        bus_start();
        send_byte(8'h31, a);
        recv_byte(1'b0, b0);
        recv_byte(1'b1, b1);
        bus_stop();
        chk("R8 pointer kept across stop", 32'({b0, b1}), 32'(exp_regs[8'h12]));
        chk("R6 pointer after pair", 32'(rd_addr), 32'h13);
        bus_start();
        send_byte(8'h31, a);
        recv_byte(1'b1, b0);
        bus_stop();
        chk("R6 high-only read reg 13", 32'(b0), 32'(exp_regs[8'h13][15:8]));
        chk("R6 no step on half pair", 32'(rd_addr), 32'h13);
        chk("R8 released after stop", 32'(sda_oe), 0);
    endtask

    task automatic t_glitch();
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(8'h30, a0);
        send_byte(8'h40, a1);
        glitch_en = 1'b1;
        send_byte(8'h12, a2);
        send_byte(8'h34, a3);
        glitch_en = 1'b0;
        bus_stop();
        exp_regs[8'h40] = 16'h1234;
        chk("R10 acks with spikes", 32'(a0 & a1 & a2 & a3), 1);
        chk("R10 value with spikes", 32'(regs[8'h40]), 32'(exp_regs[8'h40]));
        chk("R9 drive changes only with SCL low", 32'(oe_viol), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_regs[i] = init_val(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_wrap_write();
        t_partial_write();
        t_wrong_addr();
        t_read();
        t_read_retained();
        t_glitch();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end
endmodule